// File: doc/BRIEF.md
# Interrupt Pacing Timer

This block sits between the level-sensitive pending-interrupt signal from a cause/mask stage and the interrupt line to the host. It keeps a minimum spacing between successive rising edges of the interrupt line, so the interrupt rate is bounded however fast events arrive. Events that arrive while the spacing window is open are not lost. The upstream cause register keeps holding its level, and the block raises a single interrupt for all of them when the window closes.

Software programs a 16-bit spacing value. The unit is `UNIT_CYC` clock cycles; the default of 32 cycles at 125 MHz gives 256 ns per unit, so the largest value is about 16.8 ms. A value of zero turns pacing off. The window starts at each rising edge of the output. The output falls when the cause register is read, or when the pending level drops.

Top module: `irq_pacer`

## Requirements
- R1: Reset drives `irq_o` low, clears the running window and sets the spacing value to 0. The first request after reset therefore asserts at once, even if a nonzero value was in use before the reset.
- R2: With no window running, a request sampled high at a clock edge while `irq_o` is low and `ack_i` is low sets `irq_o` high after that same edge.
- R3: If `irq_o` rises at edge t, and the spacing value in force at that edge is N > 0, then `irq_o` does not rise again before edge t + N*UNIT_CYC.
- R4: Requests that arrive or stay pending inside the window give exactly one assertion, at edge t + N*UNIT_CYC. If no request is pending by then, the assertion comes at the first edge at which a request is sampled.
- R5: With a spacing value of 0, there is no pacing. After `irq_o` falls, a request sampled at the next edge asserts it again.
- R6: `ack_i` high at an edge drives `irq_o` low after that edge, even while `req_i` stays high. A request still pending is then delivered under R3/R4.
- R7: `req_i` low at an edge drives `irq_o` low after that edge.
- R8: A write to the spacing value while a window is running does not change that window. The new value applies from the next assertion onward.
- R9: `irq_o` rises only at an edge where `req_i` was sampled high. With `req_i` low, it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Raw pending-interrupt level from the cause/mask logic |
| ivl_we | input | 1 | Write strobe for the spacing value |
| ivl_wdata | input | IVL_W | New spacing value, in units of UNIT_CYC cycles |
| ack_i | input | 1 | Pulse when the cause register is read |
| irq_o | output | 1 | Paced interrupt output |

## Verification
The vector table pairs spacing values of 0, 1, 3, 10 and 300 with re-request delays that end both inside and after the window. The edge of the second assertion then shows whether the window set the timing (R3/R4) or the request did (R2, R5). Directed cases cover the following:
- an acknowledge while the request is still pending, which separates clear-on-read from clear-on-drop;
- a spacing write during a running window, which shows whether the old value or the new one is in force;
- a reset in the middle of a window, which must clear both the timer and the spacing value.

A long stretch with the request low confirms that nothing asserts without a request.

// File: rtl/irq_pacer.sv
module irq_pacer #(
  parameter int IVL_W    = 16,
  parameter int UNIT_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             ivl_we,
  input  logic [IVL_W-1:0] ivl_wdata,
  input  logic             ack_i,
  output logic             irq_o
);

  localparam int PW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(UNIT_CYC - 1);

  logic [IVL_W-1:0] ivl_q;
  logic [IVL_W-1:0] cnt_q;
  logic [PW-1:0]    pre_q;
  logic             irq_q;

  wire tick   = (pre_q == PRE_LAST);
  wire open_w = (cnt_q == '0) || (cnt_q == IVL_W'(1) && tick);
  wire set_w  = req_i && !irq_q && !ack_i && open_w;

  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ivl_q <= '0;
      cnt_q <= '0;
      pre_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ivl_we) ivl_q <= ivl_wdata;

      if (set_w)                irq_q <= 1'b1;
      else if (ack_i || !req_i) irq_q <= 1'b0;

      if (set_w) begin
        cnt_q <= ivl_q;
        pre_q <= '0;
      end else if (cnt_q != '0) begin
        if (tick) begin
          cnt_q <= cnt_q - 1'b1;
          pre_q <= '0;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end else begin
        pre_q <= '0;
      end
    end
  end

  logic [31:0] gap_q;
  logic [31:0] need_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '1;
      need_q <= '0;
    end else if (set_w) begin
      gap_q  <= 32'd1;
      need_q <= 32'(ivl_q) * 32'(UNIT_CYC);
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |-> (gap_q >= need_q));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !irq_o);

  assert_drop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !irq_o);

  assert_rise_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(req_i));

endmodule

// File: tb/sim_irq_pacer.sv
module sim_irq_pacer;
  localparam int U = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic ivl_we = 1'b0;
  logic [15:0] ivl_wdata = '0;
  logic ack_i = 1'b0;
  logic irq_o;

  irq_pacer #(.IVL_W(16), .UNIT_CYC(U)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ivl_we(ivl_we),
    .ivl_wdata(ivl_wdata), .ack_i(ack_i), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  int cyc = 0, rises = 0, last_rise = -1, errors = 0, checks = 0, cur_ivl = 0;
  logic prev = 1'b0;

  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (irq_o && !prev) begin
      rises = rises + 1;
      last_rise = cyc;
    end
    prev = irq_o;
  end

  localparam logic [31:0] VEC [8] = '{
    {16'd0,   16'd0}, {16'd0,  16'd5}, {16'd3,  16'd0}, {16'd3,  16'd10},
    {16'd10,  16'd4}, {16'd10, 16'd30}, {16'd1, 16'd0}, {16'd300, 16'd7}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ivl(input int v);
    @(negedge clk); ivl_we = 1'b1; ivl_wdata = 16'(v);
    @(negedge clk); ivl_we = 1'b0;
  endtask

  task automatic settle();
    repeat (cur_ivl * U + 4) @(negedge clk);
  endtask

  task automatic first_rise(input int v, output int e1);
    @(negedge clk); req_i = 1'b1; e1 = cyc + 1;
    @(negedge clk);
    chk("R2 first rise edge", last_rise, e1);
    cur_ivl = v;
  endtask

  task automatic ack_drop();
    ack_i = 1'b1; req_i = 1'b0;
    @(negedge clk); ack_i = 1'b0;
    chk("R6 irq after ack", int'(irq_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int e1, e2, er, ex, r0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;

    wr_ivl(50);
    first_rise(50, e1);
    @(negedge clk);
    ack_drop();

    for (int i = 0; i < 8; i++) begin
      int v = int'(VEC[i][31:16]);
      int g = int'(VEC[i][15:0]);
      settle();
      wr_ivl(v);
      first_rise(cur_ivl, e1);
      cur_ivl = v;
      r0 = rises;
      ack_drop();
      repeat (g) @(negedge clk);
      req_i = 1'b1; er = cyc + 1;
      ex = (er > e1 + v * U) ? er : e1 + v * U;
      while (cyc < ex) @(negedge clk);
      if (v == 0) chk("R5 rearm edge, no pacing", last_rise, ex);
      else        chk("R3 R4 paced rise edge", last_rise, ex);
      chk("R4 single merged rise", rises - r0, 1);
      @(negedge clk);
      ack_drop();
    end

    settle();
    wr_ivl(20);
    first_rise(20, e1);
    ack_drop();
    wr_ivl(3);
    req_i = 1'b1;
    while (cyc < e1 + 40) @(negedge clk);
    chk("R8 old window kept", last_rise, e1 + 40);
    e2 = last_rise;
    cur_ivl = 3;
    @(negedge clk);
    ack_drop();
    req_i = 1'b1;
    while (cyc < e2 + 6) @(negedge clk);
    chk("R8 new value used", last_rise, e2 + 6);
    @(negedge clk);
    ack_drop();

    settle();
    wr_ivl(5);
    first_rise(5, e1);
    r0 = rises;
    ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    chk("R6 ack with req held", int'(irq_o), 0);
    while (cyc < e1 + 10) @(negedge clk);
    chk("R6 R4 pending redelivered", last_rise, e1 + 10);
    chk("R4 one rise after race", rises - r0, 1);
    @(negedge clk);
    ack_drop();

    settle();
    wr_ivl(0);
    first_rise(0, e1);
    req_i = 1'b0;
    @(negedge clk);
    chk("R7 drop clears irq", int'(irq_o), 0);
    r0 = rises;
    repeat (20) @(negedge clk);
    chk("R9 no rise without req", rises - r0, 0);
    req_i = 1'b1; er = cyc + 1;
    @(negedge clk);
    chk("R5 immediate with zero", last_rise, er);
    @(negedge clk);
    ack_drop();

    wr_ivl(100);
    first_rise(100, e1);
    ack_drop();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 irq after mid reset", int'(irq_o), 0);
    rst_n = 1'b1;
    first_rise(0, e1);
    ack_drop();
    req_i = 1'b1; er = cyc + 1;
    @(negedge clk);
    chk("R1 spacing value cleared", last_rise, er);
    ack_drop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule